// File: doc/BRIEF.md
# RGB565 Bit-Plane Line Converter

This block turns a frame stored as 16-bit RGB565 pixels into the bit-plane line memory that a scan engine for a row-pair multiplexed LED panel shifts out. Each output element holds six bits, one per colour channel of the upper and the lower half of the panel. For every row pair and every bit plane, the converter reads two source pixels per column and tests one colour bit per component. It then writes one element per clock into the buffer that is not being displayed.

A pulse on `start` captures five settings: the canvas width, the plane count (1 to 6), the number of row pairs, a signed tile count and the buffer currently shown. Panels can be stacked vertically, with the top tile first in the canvas. A negative tile count selects serpentine stacking, where every odd tile is physically rotated. Each line is padded up to a multiple of the chunk size, and the padding elements sit at the start of the line. The source frame is read through two asynchronous read lanes, and `done` marks the end of a conversion.

Top module: `bpl_line_conv`

## Requirements
- R1: With a plane count N from 1 to 5, plane p tests red bit 11+(5-N)+p, green bit 6+(5-N)+p and blue bit (5-N)+p of each pixel.
- R2: With N = 6, plane 0 tests red bit 15, green bit 5 and blue bit 4. Plane p ≥ 1 tests red bit 10+p, green bit 5+p and blue bit p-1.
- R3: wr_data bit 0, 1 and 2 are red, green and blue of the upper-half pixel (tile row r). Bits 3, 4 and 5 are red, green and blue of the lower-half pixel (tile row r + row pairs).
- R4: Within a line, data columns come from the bottom tile first and the top tile last. Tile t occupies canvas rows t·2·rowpairs and upward. The pixel address is y·width + x.
- R5: With a negative tile count, each odd tile index is read with x mirrored to width-1-x and r mirrored to rowpairs-1-r. Its upper and lower source rows are also swapped.
- R6: A line has length L = chain rounded up to a multiple of 2^CHUNK_LG2, where chain = width·|tiles|. The first L-chain elements of each line are written as zero.
- R7: Every write lands in the buffer not selected by the captured shown_buf. Buffer 0 starts at address 0 and buffer 1 starts at L·N·rowpairs. The shown buffer is never written.
- R8: Element e of plane p of row pair r is written at buffer base + (r·N + p)·L + e. Exactly L·N·rowpairs writes are made per conversion, one per cycle.
- R9: A start pulse while busy is high is ignored, and the conversion keeps its captured settings.
- R10: busy is high from the cycle after an accepted start to the last write. done is a single-cycle pulse in the cycle after the last write.
- R11: A tile count of zero is treated as one tile.
- R12: During and right after reset, wr_en, busy and done are low, and a reset during a conversion abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion with the settings present this cycle |
| cfg_width | input | COL_W | Canvas width in pixels (one tile) |
| cfg_planes | input | 3 | Bit planes, 1 to 6 |
| cfg_rowpairs | input | RP_W | Row pairs per tile |
| cfg_tile | input | TILE_W | Signed tile count; negative means serpentine |
| shown_buf | input | 1 | Buffer currently displayed |
| pix1_addr | output | PIX_AW | Read address of the pixel feeding bits 0..2 |
| pix1_data | input | 16 | RGB565 pixel at pix1_addr, same cycle |
| pix2_addr | output | PIX_AW | Read address of the pixel feeding bits 3..5 |
| pix2_data | input | 16 | RGB565 pixel at pix2_addr, same cycle |
| wr_en | output | 1 | Plane memory write strobe |
| wr_addr | output | MEM_AW | Plane memory write address |
| wr_data | output | 6 | Six-bit element |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: a new start request and the converter's own write stream or completion. The bench provokes this by pulsing start with different settings and the other buffer selected, in the middle of a serpentine conversion. It judges the outcome by checking that every written element matches the originally captured settings, that the shown buffer stays untouched and that exactly one done pulse follows the final write. A second coincidence is a reset landing mid-stream, which must silence writes and busy at once.

// File: rtl/bpl_pkg.sv
package bpl_pkg;

    localparam int PLANE_W    = 3;
    localparam int MAX_PLANES = 6;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RUN,
        S_DRAIN
    } seq_state_t;

    typedef struct packed {
        logic b;
        logic g;
        logic r;
    } rgb_bit_t;

    // Select the colour bits tested for plane pl of an nplanes-deep image.
    function automatic rgb_bit_t pick_bits(input logic [15:0] px,
                                           input logic [PLANE_W-1:0] pl,
                                           input logic [PLANE_W-1:0] nplanes);
        int rb;
        int gb;
        int bb;
        int lift;
        rgb_bit_t res;
        if (int'(nplanes) == MAX_PLANES) begin
            gb = 5 + int'(pl);
            if (pl == '0) begin
                rb = 15;
                bb = 4;
            end else begin
                rb = 10 + int'(pl);
                bb = int'(pl) - 1;
            end
        end else begin
            lift = 5 - int'(nplanes);
            rb   = 11 + lift + int'(pl);
            gb   = 6 + lift + int'(pl);
            bb   = lift + int'(pl);
        end
        res.r = px[rb[3:0]];
        res.g = px[gb[3:0]];
        res.b = px[bb[3:0]];
        return res;
    endfunction

endpackage

// File: rtl/bpl_geom.sv
module bpl_geom #(
    parameter int COL_W     = 6,
    parameter int TILE_W    = 3,
    parameter int RP_W      = 4,
    parameter int CHUNK_LG2 = 3,
    parameter int LEN_W     = COL_W + TILE_W + 1,
    parameter int BUF_W     = LEN_W + 3 + RP_W
) (
    input  logic [COL_W-1:0]  width,
    input  logic [TILE_W-1:0] tiles,
    input  logic [2:0]        planes,
    input  logic [RP_W-1:0]   rowpairs,
    output logic [LEN_W-1:0]  line_len,
    output logic [LEN_W-1:0]  pad_len,
    output logic [BUF_W-1:0]  buf_size
);
    localparam int CHAIN_W = COL_W + TILE_W;
    localparam logic [LEN_W-1:0] CHUNK_MASK = LEN_W'((1 << CHUNK_LG2) - 1);

    logic [CHAIN_W-1:0] chain;
    logic [LEN_W-1:0]   rounded;

    assign chain    = CHAIN_W'(width) * CHAIN_W'(tiles);
    assign rounded  = LEN_W'(chain) + CHUNK_MASK;
    assign line_len = rounded & ~CHUNK_MASK;
    assign pad_len  = line_len - LEN_W'(chain);
    assign buf_size = BUF_W'(line_len) * BUF_W'(planes) * BUF_W'(rowpairs);
endmodule

// File: rtl/bpl_seq.sv
module bpl_seq
    import bpl_pkg::*;
#(
    parameter int COL_W  = 6,
    parameter int TILE_W = 3,
    parameter int RP_W   = 4,
    parameter int LEN_W  = COL_W + TILE_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [COL_W-1:0]    width,
    input  logic [PLANE_W-1:0]  planes,
    input  logic [RP_W-1:0]     rowpairs,
    input  logic [LEN_W-1:0]    line_len,
    input  logic [LEN_W-1:0]    pad_len,
    output logic                accept,
    output logic                run,
    output logic                busy,
    output logic                done,
    output logic                in_pad,
    output logic [RP_W-1:0]     row,
    output logic [PLANE_W-1:0]  plane,
    output logic [LEN_W-1:0]    elem,
    output logic [COL_W-1:0]    col,
    output logic [TILE_W-1:0]   slot
);
    seq_state_t st;
    logic line_end, plane_end, row_end, col_end, last;

    assign accept    = (st == S_IDLE) && start;
    assign run       = (st == S_RUN);
    assign busy      = (st != S_IDLE);
    assign in_pad    = elem < pad_len;
    assign line_end  = elem == (line_len - LEN_W'(1));
    assign plane_end = plane == (planes - PLANE_W'(1));
    assign row_end   = row == (rowpairs - RP_W'(1));
    assign col_end   = col == (width - COL_W'(1));
    assign last      = run && line_end && plane_end && row_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            row   <= '0;
            plane <= '0;
            elem  <= '0;
            col   <= '0;
            slot  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    st    <= S_RUN;
                    row   <= '0;
                    plane <= '0;
                    elem  <= '0;
                    col   <= '0;
                    slot  <= '0;
                end
                S_RUN: begin
                    if (line_end) begin
                        elem <= '0;
                        col  <= '0;
                        slot <= '0;
                        if (plane_end) begin
                            plane <= '0;
                            row   <= row_end ? '0 : row + RP_W'(1);
                        end else begin
                            plane <= plane + PLANE_W'(1);
                        end
                        if (last) st <= S_DRAIN;
                    end else begin
                        elem <= elem + LEN_W'(1);
                        if (!in_pad) begin
                            if (col_end) begin
                                col  <= '0;
                                slot <= slot + TILE_W'(1);
                            end else begin
                                col <= col + COL_W'(1);
                            end
                        end
                    end
                end
                S_DRAIN: begin
                    st   <= S_IDLE;
                    done <= 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R10: completion is a single-cycle pulse
    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R6: element index never leaves the line
    p_elem_bound_r6: assert property (@(posedge clk) disable iff (rst)
        run |-> (elem < line_len));
    // R6: data columns only advance past the pad region
    p_col_hold_pad_r6: assert property (@(posedge clk) disable iff (rst)
        (run && in_pad) |-> (col == '0 && slot == '0));
endmodule

// File: rtl/bpl_map.sv
module bpl_map
    import bpl_pkg::*;
#(
    parameter int COL_W  = 6,
    parameter int TILE_W = 3,
    parameter int RP_W   = 4,
    parameter int PIX_AW = COL_W + TILE_W + RP_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [COL_W-1:0]    width,
    input  logic [TILE_W-1:0]   tiles,
    input  logic                serp,
    input  logic [RP_W-1:0]     rowpairs,
    input  logic [PLANE_W-1:0]  planes,
    input  logic [RP_W-1:0]     row,
    input  logic [PLANE_W-1:0]  plane,
    input  logic [COL_W-1:0]    col,
    input  logic [TILE_W-1:0]   slot,
    output logic [PIX_AW-1:0]   pix1_addr,
    input  logic [15:0]         pix1_data,
    output logic [PIX_AW-1:0]   pix2_addr,
    input  logic [15:0]         pix2_data,
    output logic [5:0]          bits
);
    logic [TILE_W-1:0] tile_idx;
    logic              mirror;
    logic [COL_W-1:0]  xs;
    logic [RP_W-1:0]   rs;
    logic [PIX_AW-1:0] y_top, y_bot, y1, y2, canvas;
    rgb_bit_t          c1, c2;

    // bottom tile is shifted first
    assign tile_idx = tiles - TILE_W'(1) - slot;
    assign mirror   = serp & tile_idx[0];
    assign xs       = mirror ? (width - COL_W'(1) - col) : col;
    assign rs       = mirror ? (rowpairs - RP_W'(1) - row) : row;
    assign y_top    = PIX_AW'(tile_idx) * PIX_AW'({rowpairs, 1'b0}) + PIX_AW'(rs);
    assign y_bot    = y_top + PIX_AW'(rowpairs);
    assign y1       = mirror ? y_bot : y_top;
    assign y2       = mirror ? y_top : y_bot;
    assign pix1_addr = y1 * PIX_AW'(width) + PIX_AW'(xs);
    assign pix2_addr = y2 * PIX_AW'(width) + PIX_AW'(xs);

    assign c1   = pick_bits(pix1_data, plane, planes);
    assign c2   = pick_bits(pix2_data, plane, planes);
    assign bits = {c2, c1};

    assign canvas = PIX_AW'(width) * PIX_AW'(tiles) * PIX_AW'({rowpairs, 1'b0});

    // R4: both read lanes stay inside the stacked canvas
    p_lane_in_canvas_r4: assert property (@(posedge clk) disable iff (rst)
        run |-> (pix1_addr < canvas && pix2_addr < canvas));
    // R3: the two lanes always read rows one half-tile apart
    p_lane_gap_r3: assert property (@(posedge clk) disable iff (rst)
        run |-> ((pix1_addr > pix2_addr ? pix1_addr - pix2_addr : pix2_addr - pix1_addr)
                 == PIX_AW'(rowpairs) * PIX_AW'(width)));
endmodule

// File: rtl/bpl_line_conv.sv
module bpl_line_conv
    import bpl_pkg::*;
#(
    parameter int COL_W     = 6,
    parameter int TILE_W    = 3,
    parameter int RP_W      = 4,
    parameter int CHUNK_LG2 = 3,
    localparam int LEN_W    = COL_W + TILE_W + 1,
    localparam int BUF_W    = LEN_W + PLANE_W + RP_W,
    localparam int PIX_AW   = COL_W + TILE_W + RP_W + 1,
    localparam int MEM_AW   = BUF_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [COL_W-1:0]  cfg_width,
    input  logic [2:0]        cfg_planes,
    input  logic [RP_W-1:0]   cfg_rowpairs,
    input  logic [TILE_W-1:0] cfg_tile,
    input  logic              shown_buf,
    output logic [PIX_AW-1:0] pix1_addr,
    input  logic [15:0]       pix1_data,
    output logic [PIX_AW-1:0] pix2_addr,
    input  logic [15:0]       pix2_data,
    output logic              wr_en,
    output logic [MEM_AW-1:0] wr_addr,
    output logic [5:0]        wr_data,
    output logic              busy,
    output logic              done
);
    logic [COL_W-1:0]   w_q;
    logic [PLANE_W-1:0] pl_q;
    logic [RP_W-1:0]    rp_q;
    logic [TILE_W-1:0]  tiles_q;
    logic               serp_q;
    logic               disp_q;

    logic [LEN_W-1:0]   line_len, pad_len, elem;
    logic [BUF_W-1:0]   buf_size;
    logic               accept, run, in_pad;
    logic [RP_W-1:0]    row;
    logic [PLANE_W-1:0] plane;
    logic [COL_W-1:0]   col;
    logic [TILE_W-1:0]  slot;
    logic [5:0]         bits;
    logic [MEM_AW-1:0]  base, offset;
    logic [TILE_W-1:0]  tile_mag;

    assign tile_mag = (cfg_tile == '0) ? TILE_W'(1)
                    : (cfg_tile[TILE_W-1] ? (~cfg_tile + TILE_W'(1)) : cfg_tile);

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q     <= '0;
            pl_q    <= '0;
            rp_q    <= '0;
            tiles_q <= '0;
            serp_q  <= 1'b0;
            disp_q  <= 1'b0;
        end else if (accept) begin
            w_q     <= cfg_width;
            pl_q    <= cfg_planes;
            rp_q    <= cfg_rowpairs;
            tiles_q <= tile_mag;
            serp_q  <= cfg_tile[TILE_W-1];
            disp_q  <= shown_buf;
        end
    end

    bpl_geom #(.COL_W(COL_W), .TILE_W(TILE_W), .RP_W(RP_W), .CHUNK_LG2(CHUNK_LG2),
               .LEN_W(LEN_W), .BUF_W(BUF_W)) u_geom (
        .width(w_q), .tiles(tiles_q), .planes(pl_q), .rowpairs(rp_q),
        .line_len(line_len), .pad_len(pad_len), .buf_size(buf_size)
    );

    bpl_seq #(.COL_W(COL_W), .TILE_W(TILE_W), .RP_W(RP_W), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .width(w_q), .planes(pl_q), .rowpairs(rp_q),
        .line_len(line_len), .pad_len(pad_len),
        .accept(accept), .run(run), .busy(busy), .done(done), .in_pad(in_pad),
        .row(row), .plane(plane), .elem(elem), .col(col), .slot(slot)
    );

    bpl_map #(.COL_W(COL_W), .TILE_W(TILE_W), .RP_W(RP_W), .PIX_AW(PIX_AW)) u_map (
        .clk(clk), .rst(rst), .run(run),
        .width(w_q), .tiles(tiles_q), .serp(serp_q), .rowpairs(rp_q), .planes(pl_q),
        .row(row), .plane(plane), .col(col), .slot(slot),
        .pix1_addr(pix1_addr), .pix1_data(pix1_data),
        .pix2_addr(pix2_addr), .pix2_data(pix2_data),
        .bits(bits)
    );

    assign base   = disp_q ? '0 : MEM_AW'(buf_size);
    assign offset = (MEM_AW'(row) * MEM_AW'(pl_q) + MEM_AW'(plane)) * MEM_AW'(line_len)
                  + MEM_AW'(elem);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= run;
            if (run) begin
                wr_addr <= base + offset;
                wr_data <= in_pad ? 6'd0 : bits;
            end
        end
    end

    // R7: the displayed buffer is never written
    p_shown_untouched_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (disp_q ? (wr_addr < MEM_AW'(buf_size)) : (wr_addr >= MEM_AW'(buf_size))));
    // R9: settings hold while a conversion runs
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(w_q) && $stable(pl_q) && $stable(rp_q)
                             && $stable(tiles_q) && $stable(serp_q) && $stable(disp_q)));
    // R10: done comes right after a write
    p_done_after_write_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wr_en));
    // R8: writes only while the conversion is marked busy
    p_write_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);
endmodule

// File: tb/sim_bpl_line_conv.sv
module sim_bpl_line_conv;
    localparam int CLK_T  = 10;
    localparam int COL_W  = 6;
    localparam int TILE_W = 3;
    localparam int RP_W   = 4;
    localparam int PIX_AW = 14;
    localparam int MEM_AW = 18;

    typedef struct packed {
        int w;
        int n;
        int rp;
        int tile;
        int disp;
    } vec_t;

    // width, planes, rowpairs, tile, shown buffer
    localparam vec_t VECS [5] = '{
        '{3, 6, 2, -2, 0},
        '{4, 3, 2,  2, 1},
        '{5, 5, 1,  1, 0},
        '{2, 1, 4,  0, 1},
        '{3, 4, 2, -3, 1}
    };

    logic clk = 1'b0;
    always #(CLK_T/2) clk = ~clk;

    logic              rst, start, shown_buf;
    logic [COL_W-1:0]  cfg_width;
    logic [2:0]        cfg_planes;
    logic [RP_W-1:0]   cfg_rowpairs;
    logic [TILE_W-1:0] cfg_tile;
    logic [PIX_AW-1:0] pix1_addr, pix2_addr;
    logic [15:0]       pix1_data, pix2_data;
    logic              wr_en, busy, done;
    logic [MEM_AW-1:0] wr_addr;
    logic [5:0]        wr_data;

    logic [15:0] pixmem [256];
    logic [6:0]  wmem [512];

    assign pix1_data = pixmem[pix1_addr[7:0]];
    assign pix2_data = pixmem[pix2_addr[7:0]];

    bpl_line_conv u0 (
        .clk(clk), .rst(rst), .start(start),
        .cfg_width(cfg_width), .cfg_planes(cfg_planes), .cfg_rowpairs(cfg_rowpairs),
        .cfg_tile(cfg_tile), .shown_buf(shown_buf),
        .pix1_addr(pix1_addr), .pix1_data(pix1_data),
        .pix2_addr(pix2_addr), .pix2_data(pix2_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_wr, last_wr_cyc, n_done, done_cyc;
    bit finished = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wr_en) begin
            wmem[wr_addr[8:0]] <= {1'b0, wr_data};
            n_wr <= n_wr + 1;
            last_wr_cyc <= cyc;
        end
        if (done) begin
            n_done <= n_done + 1;
            done_cyc <= cyc;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_rgb(input logic [15:0] px, input int p, input int n);
        int rb, gb, bb;
        if (n == 6) begin // R2
            rb = (p == 0) ? 15 : 10 + p;
            gb = 5 + p;
            bb = (p == 0) ? 4 : p - 1;
        end else begin // R1
            rb = 11 + (5 - n) + p;
            gb = 6 + (5 - n) + p;
            bb = (5 - n) + p;
        end
        return {px[bb], px[gb], px[rb]};
    endfunction

    function automatic logic [5:0] ref_elem(input vec_t v, input int r, input int p,
                                            input int e, output string tag);
        int tiles, chain, len, pad, c, k, x, t, xs, rr, ya, yb;
        bit serp, mir;
        logic [15:0] a, b;
        tiles = (v.tile == 0) ? 1 : ((v.tile < 0) ? -v.tile : v.tile); // R11
        serp  = v.tile < 0;
        chain = v.w * tiles;
        len   = ((chain + 7) / 8) * 8;
        pad   = len - chain;
        if (e < pad) begin
            tag = "R6";
            return 6'd0;
        end
        c   = e - pad;
        k   = c / v.w;
        x   = c % v.w;
        t   = tiles - 1 - k;          // R4 bottom tile first
        mir = serp && (t % 2 == 1);   // R5
        xs  = mir ? v.w - 1 - x : x;
        rr  = mir ? v.rp - 1 - r : r;
        ya  = t * 2 * v.rp + rr;
        yb  = ya + v.rp;
        a   = pixmem[ya * v.w + xs];
        b   = pixmem[yb * v.w + xs];
        if (mir) begin
            tag = "R5";
            return {ref_rgb(a, p, v.n), ref_rgb(b, p, v.n)};
        end
        tag = (v.n == 6) ? "R2" : ((v.tile == 0) ? "R11" : "R3");
        return {ref_rgb(b, p, v.n), ref_rgb(a, p, v.n)};
    endfunction

    task automatic run_vec(input int i, input bit poke);
        vec_t v;
        int tiles, len, bsz, base, other, tmo, untouched;
        string tag;
        v = VECS[i];
        for (int a = 0; a < 256; a++) pixmem[a] = 16'(a * 40503 + i * 7919) ^ 16'(a << 5);
        for (int a = 0; a < 512; a++) wmem[a] = 7'h40;
        @(negedge clk);
        n_wr = 0;
        n_done = 0;
        cfg_width    = COL_W'(v.w);
        cfg_planes   = 3'(v.n);
        cfg_rowpairs = RP_W'(v.rp);
        cfg_tile     = TILE_W'(v.tile);
        shown_buf    = v.disp[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (7) @(negedge clk);
            chk("R10 busy mid-run", int'(busy), 1);
            cfg_width = 6'd5; cfg_planes = 3'd2; cfg_rowpairs = 4'd1;
            cfg_tile = 3'd1; shown_buf = ~shown_buf;
            start = 1'b1; // R9: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        tmo = 0;
        while (n_done == 0 && tmo < 20000) begin
            @(negedge clk);
            tmo++;
        end
        repeat (3) @(negedge clk);
        tiles = (v.tile == 0) ? 1 : ((v.tile < 0) ? -v.tile : v.tile);
        len   = ((v.w * tiles + 7) / 8) * 8;
        bsz   = len * v.n * v.rp;
        base  = v.disp ? 0 : bsz;
        other = v.disp ? bsz : 0;
        for (int r = 0; r < v.rp; r++)
            for (int p = 0; p < v.n; p++)
                for (int e = 0; e < len; e++) begin
                    logic [5:0] ex;
                    ex = ref_elem(v, r, p, e, tag);
                    // R8 placement; tag names the rule behind the value
                    chk(tag, int'(wmem[base + (r * v.n + p) * len + e]), int'({1'b0, ex}));
                end
        untouched = 0;
        for (int a = 0; a < bsz; a++) if (wmem[other + a] == 7'h40) untouched++;
        chk("R7 shown buffer untouched", untouched, bsz);
        chk("R8 write count", n_wr, bsz);
        chk("R10 done pulses", n_done, 1);
        chk("R10 done after last write", done_cyc, last_wr_cyc + 1);
        chk("R10 idle after done", int'(busy), 0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; shown_buf = 1'b0;
        cfg_width = '0; cfg_planes = '0; cfg_rowpairs = '0; cfg_tile = '0;
        n_wr = 0; n_done = 0; last_wr_cyc = 0; done_cyc = 0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 wr_en in reset", int'(wr_en), 0);
        chk("R12 busy in reset", int'(busy), 0);
        chk("R12 done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 5; i++) run_vec(i, i == 0 || i == 4);
        // R12 reset mid-conversion
        @(negedge clk);
        cfg_width = 6'd3; cfg_planes = 3'd6; cfg_rowpairs = 4'd2;
        cfg_tile = 3'd2; shown_buf = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R12 busy after abort", int'(busy), 0);
        chk("R12 wr_en after abort", int'(wr_en), 0);
        n_wr = 0;
        repeat (20) @(negedge clk);
        chk("R12 no writes after abort", n_wr, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule